// File: doc/BRIEF.md
# I/O Port Write Snoop FIFO

This block watches a decoded host I/O write strobe and keeps a copy of every data byte written to one of two programmable 16-bit port addresses. Each captured byte enters a 128-entry queue together with a one-bit tag, and a management processor drains the queue through a small byte-wide register interface. Every pop frees one slot. A single interrupt line signals either that captured data is waiting or that the host reset input has changed level.

In normal mode the tag records which of the two addresses matched. A wide-capture mode is also available. In that mode only the first address is used, as the base of a four-byte window, and the tag marks the byte written to the top port of that window. Software can then split a double-word port write back into its bytes. When the queue is full, new bytes are dropped and a sticky overflow flag is raised. The flag stays set until software has emptied the queue.

Top module: `io_snoop_fifo`

## Requirements
- R1: After a synchronous reset every register reads 0x00 and `irq` is low.
- R2: The port addresses are written one byte at a time and read back at the same offsets. Port A uses offset 0x10 for its low byte and 0x12 for its high byte. Port B uses 0x02 for its low byte and 0x04 for its high byte.
- R3: The enable register sits at offset 0x06. Bit 7 enables port A and bit 6 enables port B. When an enabled port's address matches a host write, the data byte is queued. The status register at offset 0x08 then shows bit 7 set, meaning the head entry is valid. Status bit 0 gives the head entry's tag: 0 for port A, 1 for port B.
- R4: A host write is ignored when it matches no address, or when it matches a port whose enable bit is clear.
- R5: Reading offset 0x0A returns the head data byte and pops it. Bytes come out in the order they were written.
- R6: Reading offset 0x0A while the queue is empty returns 0x00 and leaves the queue empty.
- R7: The queue holds 128 bytes. A capture that arrives while it is full is dropped and sets status bit 5. That bit stays set until the pop that empties the queue.
- R8: Enable bit 2 selects wide-capture mode. In this mode, writes to port A through port A + 3 are all queued in arrival order. The byte at port A + 3 carries tag 1 and the others carry tag 0. Port B and the address port A + 4 are ignored.
- R9: Any level change on `host_rst_in` sets bit 6 of the register at offset 0x0C. Writing that register with bit 6 set clears the flag. Writing it with bit 6 clear leaves the flag unchanged.
- R10: `irq` is high exactly when either of two conditions holds. The first is enable bit 3 set while the queue is non-empty. The second is enable bit 4 set while the reset-change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_stb | input | 1 | Decoded host I/O write strobe, one cycle per write |
| host_addr | input | 16 | Host I/O write address |
| host_data | input | 8 | Host I/O write data |
| host_rst_in | input | 1 | Host reset level, watched for changes |
| reg_wr | input | 1 | Processor register write strobe |
| reg_rd | input | 1 | Processor register read strobe (pops the queue at offset 0x0A) |
| reg_addr | input | 5 | Processor register offset |
| reg_wdata | input | 8 | Processor write data |
| reg_rdata | output | 8 | Processor read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. The queue occupancy never exceeds its depth, and a pop of an empty queue leaves it empty. A capture against a full queue raises the overflow flag. A host reset level change always sets the change flag. The interrupt follows its two enable terms. A port B tag never appears unless port B is enabled in normal mode, and in wide mode the last-byte tag appears only on the top port of the window. Other behaviour is shown only by the bench's sweeps. These cover byte ordering through the queue, the exact values read back, the overflow flag persisting through a drain of 128 entries, and the ignored-write cases.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int REG_AW    = 5;
    localparam int WIDE_SPAN = 4;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_B_LO  = 5'h02;
    localparam logic [REG_AW-1:0] OFS_B_HI  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CTL   = 5'h06;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_DATA  = 5'h0A;
    localparam logic [REG_AW-1:0] OFS_MISC  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_A_LO  = 5'h10;
    localparam logic [REG_AW-1:0] OFS_A_HI  = 5'h12;

    // control bit positions
    localparam int CTL_A_EN    = 7;
    localparam int CTL_B_EN    = 6;
    localparam int CTL_RST_IE  = 4;
    localparam int CTL_RDY_IE  = 3;
    localparam int CTL_WIDE    = 2;

    // status bit positions
    localparam int ST_VALID = 7;
    localparam int ST_OVF   = 5;
    localparam int ST_TAG   = 0;
    localparam int MS_RCHG  = 6;

    typedef struct packed {
        logic              tag;
        logic [DATA_W-1:0] data;
    } snoop_entry_t;

    function automatic logic [DATA_W-1:0] lo_byte(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] hi_byte(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/snoop_match.sv
module snoop_match
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] port_a,
    input  logic [ADDR_W-1:0] port_b,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              wide,
    output logic              hit,
    output snoop_entry_t      ent
);
    logic [ADDR_W-1:0] delta;
    logic              hit_a, hit_b, in_window;

    always_comb begin
        delta     = wr_addr - port_a;
        in_window = delta < ADDR_W'(WIDE_SPAN);
        hit_a     = en_a && (wr_addr == port_a);
        hit_b     = en_b && (wr_addr == port_b);
        ent.data  = wr_data;
        if (wide) begin
            hit     = wr_stb && in_window;
            ent.tag = (delta == ADDR_W'(WIDE_SPAN - 1));
        end else begin
            hit     = wr_stb && (hit_a || hit_b);
            ent.tag = !hit_a;
        end
    end

    // R3
    b_tag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !wide && ent.tag) |-> en_b);
    // R8
    wide_tag_top_only_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wide && ent.tag) |-> (wr_addr == port_a + ADDR_W'(WIDE_SPAN - 1)));

endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo
    import snoop_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  snoop_entry_t push_ent,
    input  logic         pop,
    output snoop_entry_t head,
    output logic         valid,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    snoop_entry_t   mem [DEPTH];
    logic [PW-1:0]  wptr, rptr;
    logic [CW-1:0]  count;
    logic           full, do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign valid   = (count != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && full)
                ovf <= 1'b1;
            else if (do_pop && !do_push && count == CW'(1))
                ovf <= 1'b0;
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);
    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !valid && !push) |=> !valid);

endmodule

// File: rtl/snoop_rstdet.sv
module snoop_rstdet (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic clr,
    output logic flag
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            prev <= lvl;
            if (lvl != prev)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    // R9
    change_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != prev) |=> flag);

endmodule

// File: rtl/io_snoop_fifo.sv
module io_snoop_fifo
    import snoop_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_stb,
    input  logic [15:0]       host_addr,
    input  logic [7:0]        host_data,
    input  logic              host_rst_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [4:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [ADDR_W-1:0] port_a, port_b;
    logic [DATA_W-1:0] ctl;
    logic              hit, f_valid, f_ovf, rchg, pop, rclr;
    snoop_entry_t      ent, head;
    logic [DATA_W-1:0] stat_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            port_a <= '0;
            port_b <= '0;
            ctl    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_A_LO: port_a[DATA_W-1:0]      <= reg_wdata;
                OFS_A_HI: port_a[ADDR_W-1:DATA_W] <= reg_wdata;
                OFS_B_LO: port_b[DATA_W-1:0]      <= reg_wdata;
                OFS_B_HI: port_b[ADDR_W-1:DATA_W] <= reg_wdata;
                OFS_CTL:  ctl                     <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign pop  = reg_rd && (reg_addr == OFS_DATA);
    assign rclr = reg_wr && (reg_addr == OFS_MISC) && reg_wdata[MS_RCHG];

    snoop_match u_match (
        .clk(clk), .rst(rst),
        .wr_stb(host_wr_stb), .wr_addr(host_addr), .wr_data(host_data),
        .port_a(port_a), .port_b(port_b),
        .en_a(ctl[CTL_A_EN]), .en_b(ctl[CTL_B_EN]), .wide(ctl[CTL_WIDE]),
        .hit(hit), .ent(ent)
    );

    snoop_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(hit), .push_ent(ent), .pop(pop),
        .head(head), .valid(f_valid), .ovf(f_ovf)
    );

    snoop_rstdet u_rstdet (
        .clk(clk), .rst(rst), .lvl(host_rst_in), .clr(rclr), .flag(rchg)
    );

    always_comb begin
        stat_v           = '0;
        stat_v[ST_VALID] = f_valid;
        stat_v[ST_OVF]   = f_ovf;
        stat_v[ST_TAG]   = f_valid && head.tag;
        case (reg_addr)
            OFS_A_LO: reg_rdata = lo_byte(port_a);
            OFS_A_HI: reg_rdata = hi_byte(port_a);
            OFS_B_LO: reg_rdata = lo_byte(port_b);
            OFS_B_HI: reg_rdata = hi_byte(port_b);
            OFS_CTL:  reg_rdata = ctl;
            OFS_STAT: reg_rdata = stat_v;
            OFS_DATA: reg_rdata = f_valid ? head.data : '0;
            OFS_MISC: reg_rdata = {1'b0, rchg, 6'b0};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = (ctl[CTL_RDY_IE] && f_valid) || (ctl[CTL_RST_IE] && rchg);

    // R10
    irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl[CTL_RDY_IE] && f_valid) |-> irq);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl[CTL_RDY_IE] && !ctl[CTL_RST_IE]) |-> !irq);

endmodule

// File: tb/io_snoop_fifo_tb.sv
module io_snoop_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr_stb = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic       host_rst_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [15:0] PA = 16'h1280;
    localparam logic [15:0] PB = 16'h3484;

    always #2 clk = ~clk;

    io_snoop_fifo dut_i (
        .clk(clk), .rst(rst), .host_wr_stb(host_wr_stb), .host_addr(host_addr),
        .host_data(host_data), .host_rst_in(host_rst_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr_stb = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [4:0] offs [8] = '{5'h02, 5'h04, 5'h06, 5'h08, 5'h0A, 5'h0C, 5'h10, 5'h12};
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (offs[k]) begin
            rd_reg(offs[k], v);
            chk("R1 reset reg", v, 8'h00);
        end
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R2 address programming
        wr_reg(5'h10, PA[7:0]); wr_reg(5'h12, PA[15:8]);
        wr_reg(5'h02, PB[7:0]); wr_reg(5'h04, PB[15:8]);
        rd_reg(5'h10, v); chk("R2 A lo", v, PA[7:0]);
        rd_reg(5'h12, v); chk("R2 A hi", v, PA[15:8]);
        rd_reg(5'h02, v); chk("R2 B lo", v, PB[7:0]);
        rd_reg(5'h04, v); chk("R2 B hi", v, PB[15:8]);

        // R3/R5 alternating ports, order and tags
        wr_reg(5'h06, 8'hC0);
        for (int i = 0; i < 16; i++)
            host_wr((i % 2) ? PB : PA, 8'(i * 13 + 5));
        for (int i = 0; i < 16; i++) begin
            rd_reg(5'h08, v); chk("R3 status", v, 8'h80 | 8'(i % 2));
            rd_reg(5'h0A, v); chk("R5 data order", v, 8'(i * 13 + 5));
        end
        rd_reg(5'h08, v); chk("R5 drained", v, 8'h00);

        // R4 disabled port and non-matching address ignored
        wr_reg(5'h06, 8'h40);
        host_wr(PA, 8'h55);
        host_wr(16'h0001, 8'h66);
        rd_reg(5'h08, v); chk("R4 ignored", v, 8'h00);

        // R6 empty pop
        rd_reg(5'h0A, v); chk("R6 empty data", v, 8'h00);
        rd_reg(5'h08, v); chk("R6 still empty", v, 8'h00);

        // R10 interrupt from ready
        wr_reg(5'h06, 8'hC8);
        host_wr(PA, 8'h11);
        #1 chk("R10 irq ready", {7'b0, irq}, 8'h01);
        rd_reg(5'h0A, v);
        #1 chk("R10 irq after drain", {7'b0, irq}, 8'h00);
        wr_reg(5'h06, 8'hC0);
        host_wr(PA, 8'h22);
        #1 chk("R10 irq masked", {7'b0, irq}, 8'h00);
        rd_reg(5'h0A, v); chk("R5 masked data", v, 8'h22);

        // R7 fill past capacity
        wr_reg(5'h06, 8'h80);
        for (int i = 0; i < 130; i++) host_wr(PA, 8'(i));
        rd_reg(5'h08, v); chk("R7 overflow flag", v, 8'hA0);
        for (int i = 0; i < 128; i++) begin
            if (i == 127) begin
                rd_reg(5'h08, v); chk("R7 overflow sticky", v, 8'hA0);
            end
            rd_reg(5'h0A, v); chk("R7 data", v, 8'(i));
        end
        rd_reg(5'h08, v); chk("R7 overflow cleared", v, 8'h00);

        // R8 wide mode
        wr_reg(5'h06, 8'h04);
        for (int k = 0; k < 5; k++) host_wr(PA + 16'(k), 8'hA0 + 8'(k));
        host_wr(PB, 8'hEE);
        for (int k = 0; k < 4; k++) begin
            rd_reg(5'h08, v); chk("R8 wide tag", v, 8'h80 | ((k == 3) ? 8'h01 : 8'h00));
            rd_reg(5'h0A, v); chk("R8 wide data", v, 8'hA0 + 8'(k));
        end
        rd_reg(5'h08, v); chk("R8 nothing extra", v, 8'h00);

        // R9 host reset change
        wr_reg(5'h06, 8'h10);
        @(negedge clk); host_rst_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_reg(5'h0C, v); chk("R9 change flag", v, 8'h40);
        #1 chk("R10 irq reset", {7'b0, irq}, 8'h01);
        wr_reg(5'h0C, 8'h00);
        rd_reg(5'h0C, v); chk("R9 write zero keeps", v, 8'h40);
        wr_reg(5'h0C, 8'h40);
        rd_reg(5'h0C, v); chk("R9 cleared", v, 8'h00);
        #1 chk("R10 irq reset cleared", {7'b0, irq}, 8'h00);
        @(negedge clk); host_rst_in = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_reg(5'h0C, v); chk("R9 falling change", v, 8'h40);

        finish_run();
    end

endmodule